// File: doc/BRIEF.md
# Character Pixel Serializer with Held Inversion

This block is the last digital stage of a character-mapped video path. It runs on the pixel clock and also receives the CPU clock, which runs at half the pixel rate. Its other inputs are the active-low memory request, a display-active qualifier, the eight-bit glyph byte from the character ROM, and the inversion bit of the fetched character code. It turns each glyph byte into a serial stream with one pixel per pixel clock. Each pixel is inverted when the character is marked inverse.

A character slot is one four-T-state opcode fetch, which is eight pixel clocks long. The block samples the CPU clock in the pixel-clock domain. A load strobe one pixel clock wide fires only when three things hold in the same cycle: the CPU clock has just risen, the memory request is inactive (high), and the display qualifier is true. Within a fetch, that combination occurs only at the start of T1. On that strobe the glyph byte is captured into a shift register and the inversion bit into a flag. The flag then applies to all eight pixels of the character, not only the first.

Top module: `glyph_serializer`

## Requirements
- R1: After a load, `pix_out` presents one glyph bit per pixel clock, most significant bit first. The register behind it shifts left by one each cycle.
- R2: A load happens only when `cpu_clk` is sampled high in a cycle after it was sampled low. Holding `cpu_clk` high for several cycles causes no further loads.
- R3: A rising `cpu_clk` causes a load only if `mreq_n` is 1 and `disp_en` is 1 in that same cycle. Otherwise the byte and the inversion bit on the inputs are discarded.
- R4: The byte on `rom_data` in the load cycle appears on `pix_out`, bit 7 through bit 0, in the 1st through 8th cycles after the load.
- R5: `inv_bit` is captured in the load cycle. Every pixel of that character equals the glyph bit XOR the captured flag (1 = inverse).
- R6: After the eight glyph bits, zeros are shifted in. `pix_out` then shows the held inversion flag until the next load.
- R7: Changes on `rom_data` and `inv_bit` in cycles without a load do not affect `pix_out`.
- R8: A synchronous active-high `rst` clears the shift register, the inversion flag, the CPU-clock history and `pix_out` to 0. The first clock edge with `rst` high does this.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_clk | input | 1 | CPU clock at half the pixel rate, sampled as data |
| mreq_n | input | 1 | Memory request, active low |
| disp_en | input | 1 | Display-active qualifier, 1 = character fetches in progress |
| rom_data | input | 8 | Glyph byte from the character ROM |
| inv_bit | input | 1 | Inversion bit of the character code, 1 = inverse |
| pix_out | output | 1 | Registered serial pixel |

## Verification
The assertions assume `cpu_clk` is a data-level signal that is stable around each pixel-clock edge. Its edges are judged only from successive samples. They also assume the glyph byte and inversion bit are valid in the one cycle where the strobe fires. The stimulus changes every input only on the falling pixel-clock edge. It models each fetch with the CPU clock high on even cycles and memory request high only at the T1 rise and on low-clock cycles. Outside the strobe cycle it puts the complement of the slot's byte and flag on the data inputs, so stale capture shows up as wrong pixels. One directed case holds the CPU clock and memory request high for eight cycles to separate edge detection from level detection.

// File: rtl/glyph_pkg.sv
package glyph_pkg;
  // Width of one glyph row in pixels (one character slot).
  localparam int unsigned GLYPH_W = 8;
  typedef logic [GLYPH_W-1:0] glyph_t;
endpackage

// File: rtl/cpu_edge_strobe.sv
module cpu_edge_strobe (
  input  logic clk,
  input  logic rst,
  input  logic cpu_clk,
  input  logic mreq_n,
  input  logic disp_en,
  output logic load_stb
);
  logic cpu_prev;
  logic cpu_rise;

  always_ff @(posedge clk) begin
    if (rst) cpu_prev <= 1'b0;
    else     cpu_prev <= cpu_clk;
  end

  // Rising edge seen as a low-to-high change between successive samples.
  assign cpu_rise = cpu_clk & ~cpu_prev;
  assign load_stb = cpu_rise & mreq_n & disp_en;
endmodule

// File: rtl/glyph_shift_reg.sv
module glyph_shift_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] par_in,
  output logic [W-1:0] sr_q,
  output logic         msb
);
  always_ff @(posedge clk) begin
    if (rst)       sr_q <= '0;
    else if (load) sr_q <= par_in;
    else           sr_q <= {sr_q[W-2:0], 1'b0};
  end

  assign msb = sr_q[W-1];
endmodule

// File: rtl/invert_stage.sv
module invert_stage (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic inv_in,
  input  logic bit_in,
  output logic inv_q,
  output logic pix_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      inv_q <= 1'b0;
      pix_q <= 1'b0;
    end else begin
      if (load) inv_q <= inv_in;
      pix_q <= bit_in ^ inv_q;
    end
  end
endmodule

// File: rtl/glyph_serializer.sv
module glyph_serializer
  import glyph_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               cpu_clk,
  input  logic               mreq_n,
  input  logic               disp_en,
  input  logic [GLYPH_W-1:0] rom_data,
  input  logic               inv_bit,
  output logic               pix_out
);
  logic   load_stb;
  glyph_t shreg_q;
  logic   shreg_msb;
  logic   inv_q;

  cpu_edge_strobe u_edge (
    .clk      (clk),
    .rst      (rst),
    .cpu_clk  (cpu_clk),
    .mreq_n   (mreq_n),
    .disp_en  (disp_en),
    .load_stb (load_stb)
  );

  glyph_shift_reg #(.W(GLYPH_W)) u_shift (
    .clk    (clk),
    .rst    (rst),
    .load   (load_stb),
    .par_in (rom_data),
    .sr_q   (shreg_q),
    .msb    (shreg_msb)
  );

  invert_stage u_inv (
    .clk    (clk),
    .rst    (rst),
    .load   (load_stb),
    .inv_in (inv_bit),
    .bit_in (shreg_msb),
    .inv_q  (inv_q),
    .pix_q  (pix_out)
  );
endmodule

// File: rtl/glyph_serializer_chk.sv
module glyph_serializer_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         cpu_clk,
  input logic         mreq_n,
  input logic         disp_en,
  input logic [W-1:0] rom_data,
  input logic         inv_bit,
  input logic         pix_out,
  input logic         load_stb,
  input logic [W-1:0] shreg,
  input logic         inv_q
);
  logic prev_cpu;
  logic armed;
  logic rst_seen;

  always_ff @(posedge clk) begin
    rst_seen <= rst;
    if (rst) begin
      prev_cpu <= 1'b0;
      armed    <= 1'b0;
    end else begin
      prev_cpu <= cpu_clk;
      armed    <= 1'b1;
    end
  end

  assert_strobe_on_rise_R2: assert property (@(posedge clk) disable iff (rst)
    load_stb |-> (cpu_clk && !prev_cpu));

  assert_strobe_qualified_R3: assert property (@(posedge clk) disable iff (rst)
    load_stb |-> (mreq_n && disp_en));

  assert_capture_byte_R4: assert property (@(posedge clk) disable iff (rst)
    load_stb |=> (shreg == $past(rom_data)));

  assert_capture_inv_R5: assert property (@(posedge clk) disable iff (rst)
    load_stb |=> (inv_q == $past(inv_bit)));

  assert_shift_msb_first_R1: assert property (@(posedge clk) disable iff (rst)
    (armed && !load_stb) |=> (shreg == {$past(shreg[W-2:0]), 1'b0}));

  assert_inv_held_R7: assert property (@(posedge clk) disable iff (rst)
    (armed && !load_stb) |=> $stable(inv_q));

  assert_pixel_xor_R5: assert property (@(posedge clk) disable iff (rst)
    armed |=> (pix_out == ($past(shreg[W-1]) ^ $past(inv_q))));

  assert_reset_clears_R8: assert property (@(posedge clk)
    rst_seen |-> (pix_out == 1'b0 && shreg == '0 && inv_q == 1'b0));
endmodule

bind glyph_serializer glyph_serializer_chk #(.W(glyph_pkg::GLYPH_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cpu_clk  (cpu_clk),
  .mreq_n   (mreq_n),
  .disp_en  (disp_en),
  .rom_data (rom_data),
  .inv_bit  (inv_bit),
  .pix_out  (pix_out),
  .load_stb (load_stb),
  .shreg    (shreg_q),
  .inv_q    (inv_q)
);

// File: tb/sim_glyph_serializer.sv
module sim_glyph_serializer;
  localparam int CLK_PERIOD = 10;
  localparam int N_SLOTS    = 8;

  // Vector fields: {rom[18:11], inv[10], disp[9], mreq_at_rise[8], expected pixels[7:0]}
  localparam logic [18:0] VEC [N_SLOTS] = '{
    {8'hA5, 1'b0, 1'b1, 1'b1, 8'hA5},  // plain load (R4)
    {8'h3C, 1'b1, 1'b1, 1'b1, 8'hC3},  // inverse load (R5)
    {8'hF0, 1'b0, 1'b0, 1'b1, 8'hFF},  // display off: no load, held inv shows (R3, R6)
    {8'h81, 1'b0, 1'b1, 1'b0, 8'hFF},  // mreq low at rise: no load (R3)
    {8'h81, 1'b0, 1'b1, 1'b1, 8'h81},  // plain load after idle (R4)
    {8'h00, 1'b1, 1'b1, 1'b1, 8'hFF},  // inverse of blank (R5)
    {8'hFF, 1'b1, 1'b1, 1'b1, 8'h00},  // inverse of full (R5)
    {8'h5A, 1'b0, 1'b1, 1'b1, 8'h5A}   // plain load (R1)
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cpu_clk = 1'b0;
  logic       mreq_n = 1'b1;
  logic       disp_en = 1'b0;
  logic [7:0] rom_data = 8'h00;
  logic       inv_bit = 1'b0;
  logic       pix_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  glyph_serializer u0 (
    .clk      (clk),
    .rst      (rst),
    .cpu_clk  (cpu_clk),
    .mreq_n   (mreq_n),
    .disp_en  (disp_en),
    .rom_data (rom_data),
    .inv_bit  (inv_bit),
    .pix_out  (pix_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic step(input logic c, input logic m, input logic d,
                      input logic [7:0] r, input logic i);
    @(negedge clk);
    cpu_clk = c; mreq_n = m; disp_en = d; rom_data = r; inv_bit = i;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic exp);
    checks++;
    if (pix_out !== exp) begin
      fails++;
      $display("FAIL %s: pix_out actual=%b expected=%b at %0t", req, pix_out, exp, $time);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R8: reset state
    step(1'b0, 1'b1, 1'b0, 8'h00, 1'b0);
    step(1'b0, 1'b1, 1'b0, 8'h00, 1'b0);
    check("R8 reset state", 1'b0);
    @(negedge clk);
    rst = 1'b0;

    // Table walk: each slot is one fetch of eight pixel clocks.
    for (int s = 0; s < N_SLOTS; s++) begin
      for (int c = 0; c < 8; c++) begin
        logic [7:0] r;
        logic       i, d, m;
        r = VEC[s][18:11];
        i = VEC[s][10];
        d = (c == 0) ? VEC[s][9] : 1'b1;
        m = (c == 0) ? VEC[s][8] : logic'(c[0]);
        if (c != 0) begin
          r = ~r;  // R7: disturb data between strobes
          i = ~i;
        end
        step(~logic'(c[0]), m, d, r, i);
        if (c != 0)
          check("R1/R4/R5/R6/R7 slot pixel", VEC[s][8-c]);
        else if (s != 0)
          check("R1/R4/R5/R6 last pixel of slot", VEC[s-1][0]);
      end
    end
    step(1'b0, 1'b1, 1'b1, 8'h00, 1'b0);
    check("R4 final pixel", VEC[N_SLOTS-1][0]);

    // R2: CPU clock held high with mreq high must not reload.
    step(1'b1, 1'b1, 1'b1, 8'hC6, 1'b0);
    for (int k = 7; k >= 1; k--) begin
      step(1'b1, 1'b1, 1'b1, 8'h00, 1'b1);
      check("R2 held-high clock no reload", 1'(8'hC6 >> k));
    end
    step(1'b0, 1'b1, 1'b1, 8'h00, 1'b1);
    check("R2 held-high clock no reload", 1'b0);
    step(1'b0, 1'b1, 1'b1, 8'h00, 1'b1);
    check("R6 zeros after glyph", 1'b0);

    // R8: reset mid-stream clears inversion flag and shifter.
    step(1'b1, 1'b1, 1'b1, 8'hFF, 1'b1);
    step(1'b0, 1'b1, 1'b1, 8'h00, 1'b0);
    check("R5 inverse load before reset", 1'b0);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R8 reset mid-stream", 1'b0);
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 3; k++) begin
      step(1'b0, 1'b1, 1'b1, 8'hFF, 1'b1);
      check("R8 state cleared after reset", 1'b0);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule